// File: doc/BRIEF.md
# Memory Array Summation Engine

This block adds up a fixed number of words held in an external synchronous memory. A one-cycle start pulse captures the array's base address, clears the running sum and the element counter, and sets a small controller running. The controller steps through the elements in ascending order. For each one it issues a single read strobe at base plus counter, takes the returned word one cycle later into the running sum, and then advances the counter. When the counter reaches the array length, the engine raises its done flag. It holds the flag and the sum until the next start.

The controller follows the loop's natural decomposition: clear, compare, fetch, add, step and finish. Each datapath register takes its input through a two-way select between its cleared value and its updated value, under enables from the controller. A parameter chooses the arithmetic variant. The first variant uses separate adders for the sum and the counter. The second uses one adder that both operations share, with its operands steered by multiplexers. The two variants give the same cycle timing and the same results.

Top module: `arr_sum_engine`

## Requirements
- R1: While reset is asserted and immediately after it, `done` is 0, `mem_rd` is 0 and `acc_out` is 0.
- R2: After a start, the engine issues exactly LEN read strobes, each one cycle wide. They go to addresses base+0, base+1, … base+LEN-1 in that order. The address is computed modulo 2^ADDR_W, so it wraps past the top of memory.
- R3: On completion, `acc_out` equals the exact sum of the LEN unsigned words read. The accumulator is DATA_W+clog2(LEN) bits wide, so a run of all-ones words does not overflow.
- R4: The word captured for each element is the one on `mem_rdata` in the cycle right after that element's strobe. `acc_out` does not change in the cycle that follows a strobe.
- R5: `done` rises 4·LEN+2 clock edges after the edge that samples `start`. No read strobe is issued while `done` is high.
- R6: Once `done` is high and `start` stays low, `done` stays high and `acc_out` stays unchanged. A start in this state clears `done` on the next edge and begins a fresh sum from zero.
- R7: A start pulse that arrives while a run is in progress has no effect. The run finishes at its original time with its original sum.
- R8: `base_addr` is sampled only on the edge that accepts a start. Changing it during a run does not alter the addresses read.
- R9: The shared-adder variant (SHARED_ADDER=1) produces the same strobes, addresses, completion time and sum as the two-adder variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| base_addr | input | ADDR_W | Address of the array's first word |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after the strobe |
| done | output | 1 | Run complete; holds until the next start |
| acc_out | output | DATA_W+clog2(LEN) | Running sum, and the final sum when done |

## Verification
The bench builds two copies side by side, one with SHARED_ADDER=0 and one with SHARED_ADDER=1. Both use DATA_W=8, ADDR_W=6 and LEN=8. With only 64 memory words, every base address can be swept under four data patterns. The sweep covers address wrap, all-zero and all-ones arrays, and the exact completion cycle in both variants at once. The short 35-cycle run also leaves room to inject stray start pulses and base changes mid-run, to hold the finished state, and to restart.

// File: rtl/arr_sum_pkg.sv
package arr_sum_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CLR  = 3'd1,
      ST_CMP  = 3'd2,
      ST_FETCH= 3'd3,
      ST_ADD  = 3'd4,
      ST_STEP = 3'd5,
      ST_FIN  = 3'd6
   } seq_state_t;

   typedef struct packed {
      logic clr;      // select cleared value on register inputs
      logic sum_en;   // enable for the running sum register
      logic cnt_en;   // enable for the element counter
      logic base_en;  // capture base address
      logic use_sum;  // shared adder operand select: 1 = sum path
   } dp_ctl_t;

endpackage

// File: rtl/arr_sum_ctrl.sv
module arr_sum_ctrl
   import arr_sum_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    cnt_below,
   output dp_ctl_t ctl,
   output logic    rd_stb,
   output logic    fin
);

   seq_state_t st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d   = st_q;
      ctl    = '0;
      rd_stb = 1'b0;
      fin    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               ctl.base_en = 1'b1;
               st_d        = ST_CLR;
            end
         end
         ST_CLR: begin
            ctl.clr    = 1'b1;
            ctl.sum_en = 1'b1;
            ctl.cnt_en = 1'b1;
            st_d       = ST_CMP;
         end
         ST_CMP: begin
            st_d = cnt_below ? ST_FETCH : ST_FIN;
         end
         ST_FETCH: begin
            rd_stb = 1'b1;
            st_d   = ST_ADD;
         end
         ST_ADD: begin
            ctl.sum_en  = 1'b1;
            ctl.use_sum = 1'b1;
            st_d        = ST_STEP;
         end
         ST_STEP: begin
            ctl.cnt_en = 1'b1;
            st_d       = ST_CMP;
         end
         ST_FIN: begin
            fin = 1'b1;
            if (start) begin
               ctl.base_en = 1'b1;
               st_d        = ST_CLR;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/arr_sum_dp.sv
module arr_sum_dp
   import arr_sum_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 16,
   parameter int LEN          = 128,
   parameter bit SHARED_ADDER = 1'b0,
   localparam int CNT_W       = $clog2(LEN + 1),
   localparam int ACC_W       = DATA_W + $clog2(LEN)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  dp_ctl_t           ctl,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic              cnt_below,
   output logic [ACC_W-1:0]  sum_q
);

   localparam int ADD_W = (ACC_W > CNT_W) ? ACC_W : CNT_W;

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] base_q;
   logic [ACC_W-1:0]  sum_upd, sum_d;
   logic [CNT_W-1:0]  cnt_upd, cnt_d;

   generate
      if (SHARED_ADDER) begin : g_one_adder
         logic [ADD_W-1:0] op_a, op_b, res;
         always_comb begin
            op_a = ctl.use_sum ? ADD_W'(sum_q) : ADD_W'(cnt_q);
            op_b = ctl.use_sum ? ADD_W'(rdata) : ADD_W'(1);
            res  = op_a + op_b;
         end
         assign sum_upd = res[ACC_W-1:0];
         assign cnt_upd = res[CNT_W-1:0];
      end else begin : g_two_adders
         assign sum_upd = sum_q + ACC_W'(rdata);
         assign cnt_upd = cnt_q + CNT_W'(1);
      end
   endgenerate

   // two-way selects between cleared value and update value
   assign sum_d = ctl.clr ? '0 : sum_upd;
   assign cnt_d = ctl.clr ? '0 : cnt_upd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q  <= '0;
         cnt_q  <= '0;
         base_q <= '0;
      end else begin
         if (ctl.sum_en)  sum_q  <= sum_d;
         if (ctl.cnt_en)  cnt_q  <= cnt_d;
         if (ctl.base_en) base_q <= base_in;
      end
   end

   assign cnt_below = (cnt_q < CNT_W'(LEN));
   assign addr      = base_q + ADDR_W'(cnt_q);

endmodule

// File: rtl/arr_sum_engine.sv
module arr_sum_engine
   import arr_sum_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 16,
   parameter int LEN          = 128,
   parameter bit SHARED_ADDER = 1'b0,
   localparam int ACC_W       = DATA_W + $clog2(LEN)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [ACC_W-1:0]  acc_out
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("arr_sum_engine: DATA_W must be at least 1");
      end
      if (LEN < 1) begin : g_bad_len
         $error("arr_sum_engine: LEN must be at least 1");
      end
      if (ADDR_W < $clog2(LEN + 1)) begin : g_bad_addr_w
         $error("arr_sum_engine: ADDR_W too narrow for LEN");
      end
   endgenerate

   dp_ctl_t ctl;
   logic    cnt_below;

   arr_sum_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cnt_below (cnt_below),
      .ctl       (ctl),
      .rd_stb    (mem_rd),
      .fin       (done)
   );

   arr_sum_dp #(
      .DATA_W       (DATA_W),
      .ADDR_W       (ADDR_W),
      .LEN          (LEN),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .base_in   (base_addr),
      .rdata     (mem_rdata),
      .addr      (mem_addr),
      .cnt_below (cnt_below),
      .sum_q     (acc_out)
   );

endmodule

// File: rtl/arr_sum_chk.sv
module arr_sum_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 16,
   parameter int LEN    = 128,
   localparam int ACC_W = DATA_W + $clog2(LEN)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              done,
   input logic [ACC_W-1:0]  acc_out
);

   // R2 / R4: strobe is one cycle wide and the sum is untouched in the data cycle
   assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && $stable(acc_out)));

   // R2: successive strobes in a run step the address by one
   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(mem_rd, 4)) |-> (mem_addr == ADDR_W'($past(mem_addr, 4) + 1'b1)));

   // R5: no read while finished
   assert_no_read_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd);

   // R6: finished state holds until a start
   assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(acc_out)));

   // R6: a start in the finished state drops done
   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> !done);

endmodule

bind arr_sum_engine arr_sum_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .LEN    (LEN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .done     (done),
   .acc_out  (acc_out)
);

// File: tb/sim_arr_sum_engine.sv
`timescale 1ns/1ps
module sim_arr_sum_engine;

   localparam int DW  = 8;
   localparam int AW  = 6;
   localparam int L   = 8;
   localparam int AC  = DW + $clog2(L);
   localparam int MEMN = 1 << AW;
   localparam int LAT = 4 * L + 3;  // negedges counted from the start edge

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] base = '0;

   logic [AW-1:0] addr0, addr1;
   logic rd0, rd1, done0, done1;
   logic [DW-1:0] rdat0, rdat1;
   logic [AC-1:0] acc0, acc1;

   logic [DW-1:0] mem [MEMN];

   int vecs = 0;
   int errs = 0;
   bit finished = 1'b0;

   int n0, n1;
   logic [AW-1:0] log0 [16];
   logic [AW-1:0] log1 [16];

   always #2.5 clk = ~clk;

   arr_sum_engine #(.DATA_W(DW), .ADDR_W(AW), .LEN(L), .SHARED_ADDER(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base),
      .mem_addr(addr0), .mem_rd(rd0), .mem_rdata(rdat0), .done(done0), .acc_out(acc0));

   arr_sum_engine #(.DATA_W(DW), .ADDR_W(AW), .LEN(L), .SHARED_ADDER(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base),
      .mem_addr(addr1), .mem_rd(rd1), .mem_rdata(rdat1), .done(done1), .acc_out(acc1));

   // memory models: valid data only in the cycle after a strobe, junk otherwise
   always_ff @(posedge clk) begin
      rdat0 <= rd0 ? mem[addr0] : ~mem[addr0];
      rdat1 <= rd1 ? mem[addr1] : ~mem[addr1];
   end

   // strobe log sampled away from the edge
   always @(negedge clk) begin
      if (rd0) begin if (n0 < 16) log0[n0] = addr0; n0 = n0 + 1; end
      if (rd1) begin if (n1 < 16) log1[n1] = addr1; n1 = n1 + 1; end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int p, input int a);
      case (p)
         0:       return '0;
         1:       return '1;
         2:       return DW'(a * 3 + 1);
         default: return DW'((a * 37) ^ 8'h6C);
      endcase
   endfunction

   function automatic longint exp_sum(input int b);
      longint s = 0;
      for (int i = 0; i < L; i++) s += mem[(b + i) % MEMN];
      return s;
   endfunction

   // one run: poke > 0 injects a start and a base change at that count
   task automatic run(input int b, input int poke, input bit from_done);
      int cyc;
      bit ok0, ok1;
      longint es;
      es = exp_sum(b);
      @(negedge clk);
      n0 = 0; n1 = 0;
      base = AW'(b);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      if (from_done)
         check(!done0 && !done1, "R6", "done cleared by restart", done0, 0);
      while (!done0 && cyc < 200) begin
         if (poke != 0 && cyc == poke) begin
            start = 1'b1;
            base = AW'(b ^ 21);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(cyc == LAT, poke ? "R7" : "R5", "completion latency", cyc, LAT);
      check(done1 == done0, "R9", "shared variant done timing", done1, done0);
      check(acc0 == AC'(es), poke ? "R8" : "R3", "sum two-adder", acc0, es);
      check(acc1 == AC'(es), "R9", "sum shared-adder", acc1, es);
      check(n0 == L && n1 == L, "R2", "strobe count", n0, L);
      ok0 = 1'b1; ok1 = 1'b1;
      for (int i = 0; i < L; i++) begin
         if (log0[i] != AW'(b + i)) ok0 = 1'b0;
         if (log1[i] != AW'(b + i)) ok1 = 1'b0;
      end
      check(ok0, "R2", "address order two-adder", log0[0], b);
      check(ok1, "R9", "address order shared-adder", log1[0], b);
   endtask

   initial begin
      logic [AC-1:0] held;
      for (int a = 0; a < MEMN; a++) mem[a] = pat(2, a);
      repeat (3) @(negedge clk);
      check(!done0 && !rd0 && acc0 == 0, "R1", "outputs during reset", acc0, 0);
      check(!done1 && !rd1 && acc1 == 0, "R1", "shared outputs during reset", acc1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done0 && !rd0 && acc0 == 0, "R1", "outputs after reset", acc0, 0);

      // sweep: every base under every pattern (R2, R3, R4 via junk data)
      for (int p = 0; p < 4; p++) begin
         for (int a = 0; a < MEMN; a++) mem[a] = pat(p, a);
         for (int b = 0; b < MEMN; b++) run(b, 0, !(p == 0 && b == 0));
      end

      // hold after completion: change memory and base, no start (R6)
      held = acc0;
      for (int a = 0; a < MEMN; a++) mem[a] = pat(3, a + 5);
      base = 6'd17;
      repeat (12) @(negedge clk);
      check(done0 && done1, "R6", "done held", done0, 1);
      check(acc0 == held && acc1 == held, "R6", "sum held", acc0, held);

      // restart clears the previous sum (R6), stray start mid-run (R7), base change (R8)
      run(9, 0, 1'b1);
      for (int k = 2; k < LAT - 2; k += 5) run(40, k, 1'b1);
      run(61, 3, 1'b1);

      // all-ones worst case at a wrapping base (R3)
      for (int a = 0; a < MEMN; a++) mem[a] = '1;
      run(59, 0, 1'b1);
      check(acc0 == AC'(L * ((1 << DW) - 1)), "R3", "full-scale sum", acc0, L * ((1 << DW) - 1));

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      #(150000 * 5);
      if (!finished) begin
         finished = 1'b1;
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

endmodule